// File: doc/BRIEF.md
# Device-Control Broadcast Command Decoder

This block sits behind the byte-level front end of an I3C target. It decodes the generic-access form of the device-control common command. The front end supplies the received bytes one at a time. It also marks each start, repeated start and stop with a pulse, reports parity errors, and states whether packet error checking (PEC) is on. From these inputs the decoder decides three things: whether the command is for this device, where each data byte falls among four logical control bytes, and whether the frame was received complete and free of errors. Only after that does it change its configuration outputs.

A frame opens with a start or repeated start. Its bytes, in order, are: the broadcast header 0xFC, the command code, a control byte, a target-address byte, one or more data bytes, and a PEC byte when checking is on. The decoder answers the command-code byte with an ACK or NACK decision. If the frame passes every check, the decoder commits the staged bits at the stop or repeated start that ends it. The committed bits are the PEC-enable bit, the parity-disable bit and a one-cycle pulse that clears pending interrupts. A frame in specific-register-access mode is not decoded further; the decoder only flags it.

Top module: `dctl_ccc_decoder`

## Requirements
- R1: While reset is high and in the cycle after it is released, `cfg_pec_en_o`, `cfg_par_dis_o`, `irq_clr_o`, `ack_valid_o` and `reg_access_o` are 0.
- R2: The decoder ignores a frame, with no ACK decision and no change, unless the first byte after the start or repeated start is 0xFC and the second byte equals the `CMD_CODE` parameter (default 0x62).
- R3: One cycle after an accepted command-code byte, `ack_valid_o` is 1 for one cycle. `ack_o` is 0 (NACK) if the frame began with a repeated start and the previous frame had a PEC mismatch; otherwise `ack_o` is 1. A NACKed frame applies nothing.
- R4: The control byte holds the fields [7:5] address mask, [4] mode (0 generic, 1 register access), [3:2] start offset and [1:0] burst length minus one. The address byte carries the target in [7:1]; bit [0] is ignored.
- R5: Address mask 000 needs the target to equal `own_addr_i`. Mask 011 compares only target[6:3] with `own_addr_i[6:3]`. Mask 111 matches any target. Every other mask value fails to match. A frame that does not match applies nothing.
- R6: Data byte i (counting from 0) goes to logical byte start offset + i. A byte whose position would be beyond logical byte 3 is dropped.
- R7: In logical byte 0, bit 7 sets `cfg_pec_en_o` and bit 6 sets `cfg_par_dis_o`. Bits 5:0 have no effect.
- R8: If logical byte 1 bit 3 is 1 at commit, `irq_clr_o` pulses for exactly one cycle. All other bits of byte 1, and all of bytes 2 and 3, have no effect.
- R9: `pec_mode_i` is sampled at the start or repeated start. With PEC on, the frame carries exactly burst+1 data bytes followed by a PEC byte. That byte is a CRC-8 with polynomial 0x07, initial value 0x00, processed MSB first, computed over the bytes from the command code through the last data byte. Bytes after the PEC byte are ignored.
- R10: A PEC mismatch applies nothing, produces no pulse, and marks the frame as erroneous.
- R11: A complete frame applies its changes only at the stop or repeated start that ends it, and the new outputs are visible one cycle later. A frame applies nothing if it lacks bytes: with PEC on, fewer than burst+1 data bytes or no PEC byte; with PEC off, no data byte at all.
- R12: If the mode bit is 1 and the address matches, `reg_access_o` pulses one cycle after the address byte. The rest of that frame is ignored and applies nothing.
- R13: A `par_err_i` pulse during a frame marks that frame as erroneous, in the same way as a PEC mismatch for the NACK rule of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid_i | input | 1 | A received byte is present on `rx_data_i` |
| rx_data_i | input | 8 | Received byte |
| rx_start_i | input | 1 | Start marker pulse |
| rx_rstart_i | input | 1 | Repeated-start marker pulse |
| rx_stop_i | input | 1 | Stop marker pulse |
| pec_mode_i | input | 1 | PEC checking on for the frame being opened |
| par_err_i | input | 1 | Parity-error pulse from the front end |
| own_addr_i | input | 7 | Serial address of this device |
| cfg_pec_en_o | output | 1 | Committed PEC-enable bit |
| cfg_par_dis_o | output | 1 | Committed parity-disable bit |
| irq_clr_o | output | 1 | One-cycle pulse that clears pending interrupts |
| ack_valid_o | output | 1 | ACK decision strobe |
| ack_o | output | 1 | 1 = ACK, 0 = NACK, valid while `ack_valid_o` is high |
| reg_access_o | output | 1 | One-cycle pulse flagging a register-access frame |

## Verification
Each byte-driven result is registered once. The ACK strobe and the register-access flag appear in the cycle after the command-code byte and the address byte. The committed configuration bits and the clear pulse appear in the cycle after the stop or repeated-start marker, and the clear pulse must be low again one cycle after that. The bench drives every byte or marker for one cycle from a falling edge. It samples the outputs at the next falling edge, after the one rising edge that registered them. For the clear pulse it samples one further falling edge to check that the pulse has ended.

// File: rtl/dctl_pkg.sv
package dctl_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int GRP_W    = 4;
    localparam logic [BYTE_W-1:0] BCAST_HDR = 8'hFC;

    localparam logic [2:0] MASK_UNI = 3'b000;
    localparam logic [2:0] MASK_GRP = 3'b011;
    localparam logic [2:0] MASK_ALL = 3'b111;

    // Bit positions inside the logical control bytes
    localparam int BIT_PEC_EN  = 7;
    localparam int BIT_PAR_DIS = 6;
    localparam int BIT_IRQ_CLR = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_CODE,
        ST_CTRL,
        ST_ADDR,
        ST_DATA,
        ST_PEC,
        ST_TAIL
    } frame_st_e;

    typedef struct packed {
        logic [2:0] mask;
        logic       regmode;
        logic [1:0] offset;
        logic [1:0] burst;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] crc8_step(input logic [BYTE_W-1:0] crc,
                                                    input logic [BYTE_W-1:0] din,
                                                    input logic [BYTE_W-1:0] poly);
        logic [BYTE_W-1:0] c;
        logic              fb;
        c = crc;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = c[BYTE_W-1] ^ din[i];
            c  = {c[BYTE_W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        return c;
    endfunction

    function automatic logic addr_hit(input logic [2:0]        mask,
                                      input logic [ADDR_W-1:0] tgt,
                                      input logic [ADDR_W-1:0] own);
        case (mask)
            MASK_UNI: return tgt == own;
            MASK_GRP: return tgt[ADDR_W-1 -: GRP_W] == own[ADDR_W-1 -: GRP_W];
            MASK_ALL: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dctl_crc8.sv
module dctl_crc8
    import dctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07,
    parameter logic [BYTE_W-1:0] SEED = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              update,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc_q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            crc_q <= SEED;
        end else if (update) begin
            crc_q <= crc8_step(crc_q, din, POLY);
        end
    end

endmodule

// File: rtl/dctl_frame_ctrl.sv
module dctl_frame_ctrl
    import dctl_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CMD_CODE = 8'h62,
    parameter int                NUM_LB   = 4,
    localparam int               LB_W     = $clog2(NUM_LB),
    localparam int               CNT_W    = LB_W + 1,
    localparam int               POS_W    = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    input  logic              rx_start_i,
    input  logic              rx_rstart_i,
    input  logic              rx_stop_i,
    input  logic              pec_mode_i,
    input  logic              par_err_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [BYTE_W-1:0] crc_q,
    output logic              crc_clear,
    output logic              crc_update,
    output logic              frame_begin,
    output logic              wr_en,
    output logic [LB_W-1:0]   wr_pos,
    output logic              commit,
    output logic              ack_valid_o,
    output logic              ack_o,
    output logic              reg_access_o
);

    frame_st_e        st_q;
    ctrl_t            ctrl_q;
    logic             pec_q;
    logic             nack_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt_q;
    logic [POS_W-1:0] pos;
    logic             byte_in;

    assign frame_begin = rx_start_i | rx_rstart_i;
    assign byte_in     = rx_valid_i & ~frame_begin & ~rx_stop_i;
    assign pos         = POS_W'(ctrl_q.offset) + POS_W'(cnt_q);
    assign wr_en       = byte_in && (st_q == ST_DATA) && (pos < POS_W'(NUM_LB));
    assign wr_pos      = pos[LB_W-1:0];

    assign crc_clear   = frame_begin;
    assign crc_update  = byte_in && (st_q == ST_CODE || st_q == ST_CTRL ||
                                     st_q == ST_ADDR || st_q == ST_DATA);

    // A frame is complete only with all of its bytes and, in PEC mode, a good check byte
    assign commit = (rx_stop_i | rx_rstart_i) &&
                    ((st_q == ST_DATA && !pec_q && cnt_q != '0) || st_q == ST_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            ctrl_q       <= '0;
            pec_q        <= 1'b0;
            nack_q       <= 1'b0;
            err_q        <= 1'b0;
            cnt_q        <= '0;
            ack_valid_o  <= 1'b0;
            ack_o        <= 1'b0;
            reg_access_o <= 1'b0;
        end else begin
            ack_valid_o  <= 1'b0;
            reg_access_o <= 1'b0;
            if (par_err_i) begin
                err_q <= 1'b1;
            end
            if (frame_begin) begin
                st_q   <= ST_HDR;
                nack_q <= rx_rstart_i & err_q;
                err_q  <= 1'b0;
                pec_q  <= pec_mode_i;
                cnt_q  <= '0;
            end else if (rx_stop_i) begin
                st_q <= ST_IDLE;
            end else if (rx_valid_i) begin
                case (st_q)
                    ST_HDR:  st_q <= (rx_data_i == BCAST_HDR) ? ST_CODE : ST_IDLE;
                    ST_CODE: begin
                        if (rx_data_i == CMD_CODE) begin
                            ack_valid_o <= 1'b1;
                            ack_o       <= ~nack_q;
                            st_q        <= nack_q ? ST_IDLE : ST_CTRL;
                        end else begin
                            st_q <= ST_IDLE;
                        end
                    end
                    ST_CTRL: begin
                        ctrl_q <= ctrl_t'(rx_data_i);
                        st_q   <= ST_ADDR;
                    end
                    ST_ADDR: begin
                        if (!addr_hit(ctrl_q.mask, rx_data_i[BYTE_W-1:1], own_addr_i)) begin
                            st_q <= ST_IDLE;
                        end else if (ctrl_q.regmode) begin
                            reg_access_o <= 1'b1;
                            st_q         <= ST_IDLE;
                        end else begin
                            st_q <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q != CNT_W'(NUM_LB)) begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                        if (pec_q && cnt_q == CNT_W'(ctrl_q.burst)) begin
                            st_q <= ST_PEC;
                        end
                    end
                    ST_PEC: begin
                        if (rx_data_i == crc_q) begin
                            st_q <= ST_TAIL;
                        end else begin
                            err_q <= 1'b1;
                            st_q  <= ST_IDLE;
                        end
                    end
                    default: st_q <= st_q;
                endcase
            end
        end
    end

    AST_ACK_ON_CODE: assert property (@(posedge clk) disable iff (rst)
        ack_valid_o |-> $past(rx_valid_i && rx_data_i == CMD_CODE)); // R3

    AST_REGACC_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        reg_access_o |-> ($past(rx_valid_i) && !ack_valid_o)); // R12

endmodule

// File: rtl/dctl_cfg_stage.sv
module dctl_cfg_stage
    import dctl_pkg::*;
#(
    parameter int   NUM_LB      = 4,
    parameter logic PEC_EN_RST  = 1'b0,
    parameter logic PAR_DIS_RST = 1'b0,
    localparam int  LB_W        = $clog2(NUM_LB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_begin,
    input  logic              wr_en,
    input  logic [LB_W-1:0]   wr_pos,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              commit,
    output logic              cfg_pec_en_o,
    output logic              cfg_par_dis_o,
    output logic              irq_clr_o
);

    logic lb0_vld_q;
    logic lb0_pec_q;
    logic lb0_par_q;
    logic lb1_clr_q;
    logic unused_bits;

    // Reserved bits of every logical byte are never stored
    assign unused_bits = ^{wr_data[5:4], wr_data[2:0]};

    always_ff @(posedge clk) begin
        if (rst || frame_begin) begin
            lb0_vld_q <= 1'b0;
            lb0_pec_q <= 1'b0;
            lb0_par_q <= 1'b0;
            lb1_clr_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_pos == LB_W'(0)) begin
                lb0_vld_q <= 1'b1;
                lb0_pec_q <= wr_data[BIT_PEC_EN];
                lb0_par_q <= wr_data[BIT_PAR_DIS];
            end
            if (wr_pos == LB_W'(1)) begin
                lb1_clr_q <= wr_data[BIT_IRQ_CLR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_pec_en_o  <= PEC_EN_RST;
            cfg_par_dis_o <= PAR_DIS_RST;
            irq_clr_o     <= 1'b0;
        end else begin
            irq_clr_o <= commit & lb1_clr_q;
            if (commit && lb0_vld_q) begin
                cfg_pec_en_o  <= lb0_pec_q;
                cfg_par_dis_o <= lb0_par_q;
            end
        end
    end

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        irq_clr_o |=> !irq_clr_o); // R8

    AST_CLR_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst)
        irq_clr_o |-> $past(commit)); // R11

    AST_PEC_EN_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(cfg_pec_en_o)); // R11

    AST_PAR_DIS_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !$past(commit) |-> $stable(cfg_par_dis_o)); // R11

endmodule

// File: rtl/dctl_ccc_decoder.sv
module dctl_ccc_decoder
    import dctl_pkg::*;
#(
    parameter logic [7:0] CMD_CODE    = 8'h62,
    parameter int         NUM_LB      = 4,
    parameter logic [7:0] CRC_POLY    = 8'h07,
    parameter logic       PEC_EN_RST  = 1'b0,
    parameter logic       PAR_DIS_RST = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    input  logic       rx_start_i,
    input  logic       rx_rstart_i,
    input  logic       rx_stop_i,
    input  logic       pec_mode_i,
    input  logic       par_err_i,
    input  logic [6:0] own_addr_i,
    output logic       cfg_pec_en_o,
    output logic       cfg_par_dis_o,
    output logic       irq_clr_o,
    output logic       ack_valid_o,
    output logic       ack_o,
    output logic       reg_access_o
);

    localparam int LB_W = $clog2(NUM_LB);

    logic              crc_clear;
    logic              crc_update;
    logic [BYTE_W-1:0] crc_q;
    logic              frame_begin;
    logic              wr_en;
    logic [LB_W-1:0]   wr_pos;
    logic              commit;

    dctl_crc8 #(
        .POLY (CRC_POLY),
        .SEED (8'h00)
    ) u_crc (
        .clk    (clk),
        .rst    (rst),
        .clear  (crc_clear),
        .update (crc_update),
        .din    (rx_data_i),
        .crc_q  (crc_q)
    );

    dctl_frame_ctrl #(
        .CMD_CODE (CMD_CODE),
        .NUM_LB   (NUM_LB)
    ) u_frame (
        .clk          (clk),
        .rst          (rst),
        .rx_valid_i   (rx_valid_i),
        .rx_data_i    (rx_data_i),
        .rx_start_i   (rx_start_i),
        .rx_rstart_i  (rx_rstart_i),
        .rx_stop_i    (rx_stop_i),
        .pec_mode_i   (pec_mode_i),
        .par_err_i    (par_err_i),
        .own_addr_i   (own_addr_i),
        .crc_q        (crc_q),
        .crc_clear    (crc_clear),
        .crc_update   (crc_update),
        .frame_begin  (frame_begin),
        .wr_en        (wr_en),
        .wr_pos       (wr_pos),
        .commit       (commit),
        .ack_valid_o  (ack_valid_o),
        .ack_o        (ack_o),
        .reg_access_o (reg_access_o)
    );

    dctl_cfg_stage #(
        .NUM_LB      (NUM_LB),
        .PEC_EN_RST  (PEC_EN_RST),
        .PAR_DIS_RST (PAR_DIS_RST)
    ) u_stage (
        .clk           (clk),
        .rst           (rst),
        .frame_begin   (frame_begin),
        .wr_en         (wr_en),
        .wr_pos        (wr_pos),
        .wr_data       (rx_data_i),
        .commit        (commit),
        .cfg_pec_en_o  (cfg_pec_en_o),
        .cfg_par_dis_o (cfg_par_dis_o),
        .irq_clr_o     (irq_clr_o)
    );

    AST_COMMIT_ONLY_ON_END: assert property (@(posedge clk) disable iff (rst)
        commit |-> (rx_stop_i || rx_rstart_i)); // R11

endmodule

// File: tb/dctl_ccc_decoder_tb.sv
`timescale 1ns/1ps
module dctl_ccc_decoder_tb;

    localparam logic [7:0] CMD = 8'h62;
    localparam logic [6:0] OWN = 7'h35;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_data_i = 8'h00;
    logic       rx_start_i = 1'b0;
    logic       rx_rstart_i = 1'b0;
    logic       rx_stop_i = 1'b0;
    logic       pec_mode_i = 1'b0;
    logic       par_err_i = 1'b0;
    logic [6:0] own_addr_i = OWN;
    logic       cfg_pec_en_o, cfg_par_dis_o, irq_clr_o, ack_valid_o, ack_o, reg_access_o;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    bit   e_pec = 0, e_par = 0;
    bit   err_cur = 0, err_par = 0;
    bit   pend_v = 0, pend_b0 = 0, pend_pec = 0, pend_par = 0, pend_clr = 0;
    string pend_tag = "R11";
    bit   open_fr = 0;
    logic [7:0] dat [5];

    always #2 clk = ~clk;

    dctl_ccc_decoder u_dut (
        .clk(clk), .rst(rst), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
        .rx_start_i(rx_start_i), .rx_rstart_i(rx_rstart_i), .rx_stop_i(rx_stop_i),
        .pec_mode_i(pec_mode_i), .par_err_i(par_err_i), .own_addr_i(own_addr_i),
        .cfg_pec_en_o(cfg_pec_en_o), .cfg_par_dis_o(cfg_par_dis_o), .irq_clr_o(irq_clr_o),
        .ack_valid_o(ack_valid_o), .ack_o(ack_o), .reg_access_o(reg_access_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // CRC-8, poly 0x07, by long division of a 16-bit dividend
    function automatic logic [7:0] b_crc(input logic [7:0] c, input logic [7:0] b);
        logic [15:0] t;
        t = {c ^ b, 8'h00};
        for (int k = 15; k >= 8; k--)
            if (t[k]) t = t ^ (16'h0107 << (k - 8));
        return t[7:0];
    endfunction

    function automatic bit b_hit(input logic [2:0] m, input logic [6:0] tgt);
        if (m == 3'b111) return 1;
        if (m == 3'b011) return tgt[6:3] == OWN[6:3];
        if (m == 3'b000) return tgt == OWN;
        return 0;
    endfunction

    task automatic check_pending();
        bit exp_clr;
        exp_clr = pend_v && pend_clr;
        if (pend_v && pend_b0) begin
            e_pec = pend_pec;
            e_par = pend_par;
        end
        chk({pend_tag, " R7 pec_en"}, cfg_pec_en_o, e_pec);
        chk({pend_tag, " R7 par_dis"}, cfg_par_dis_o, e_par);
        chk({pend_tag, " R8 irq_clr"}, irq_clr_o, exp_clr);
        @(negedge clk);
        chk("R8 irq_clr single cycle", irq_clr_o, 0);
        pend_v = 0;
    endtask

    task automatic do_stop();
        rx_stop_i = 1'b1;
        @(negedge clk);
        rx_stop_i = 1'b0;
        check_pending();
        open_fr = 0;
    endtask

    task automatic run_frame(input bit rs, input bit pec, input logic [7:0] hdr,
                             input logic [7:0] code, input logic [7:0] ctrl,
                             input logic [7:0] addr, input int nd, input int pk,
                             input int tail, input bit par);
        logic [7:0] seq [16];
        logic [7:0] crc;
        int  n, pos;
        bit  ok, hit, gen, nack, nackp, cmpl, bad, b0, b0p, b0r, clr;
        if (!rs && open_fr) do_stop();
        nack  = rs && err_cur;
        nackp = rs && err_par;
        err_cur = 0;
        err_par = 0;
        pec_mode_i = pec;
        if (rs) rx_rstart_i = 1'b1; else rx_start_i = 1'b1;
        @(negedge clk);
        rx_rstart_i = 1'b0;
        rx_start_i  = 1'b0;
        if (rs) check_pending();
        open_fr = 1;
        // Build the byte sequence
        seq[0] = hdr; seq[1] = code; seq[2] = ctrl; seq[3] = addr;
        n = 4;
        crc = 8'h00;
        for (int i = 1; i < 4; i++) crc = b_crc(crc, seq[i]);
        for (int i = 0; i < nd; i++) begin
            seq[n] = dat[i];
            crc = b_crc(crc, dat[i]);
            n++;
        end
        if (pk == 1) begin seq[n] = crc; n++; end
        if (pk == 2) begin seq[n] = crc ^ (8'h01 << ($urandom % 8)); n++; end
        for (int i = 0; i < tail; i++) begin seq[n] = 8'($urandom); n++; end
        ok  = (hdr == 8'hFC) && (code == CMD);
        hit = b_hit(ctrl[7:5], addr[7:1]);
        gen = ok && !nack && hit && !ctrl[4];
        for (int i = 0; i < n; i++) begin
            rx_valid_i = 1'b1;
            rx_data_i  = seq[i];
            @(negedge clk);
            rx_valid_i = 1'b0;
            if (i == 1) begin
                chk(ok ? (nackp ? "R13 ack strobe" : "R3 ack strobe") : "R2 no ack strobe",
                    ack_valid_o, ok);
                if (ok) chk(nackp ? "R13 ack value" : "R3 ack value", ack_o, !nack);
            end
            if (i == 3) chk("R12 R5 reg_access", reg_access_o, ok && !nack && hit && ctrl[4]);
            if ($urandom % 4 == 0) @(negedge clk);
        end
        if (par) begin
            par_err_i = 1'b1;
            @(negedge clk);
            par_err_i = 1'b0;
            err_cur = 1;
            err_par = 1;
        end
        // Expected outcome (R4 field layout, R6 placement, R9 count)
        if (pec) begin
            cmpl = (nd == int'(ctrl[1:0]) + 1) && (pk != 0);
            bad  = (pk == 2);
        end else begin
            cmpl = (nd >= 1);
            bad  = 0;
        end
        if (gen && pec && cmpl && bad) err_cur = 1;
        b0 = 0; b0p = 0; b0r = 0; clr = 0;
        for (int i = 0; i < nd; i++) begin
            pos = int'(ctrl[3:2]) + i;
            if (pos == 0) begin b0 = 1; b0p = dat[i][7]; b0r = dat[i][6]; end
            if (pos == 1) clr = dat[i][3];
        end
        pend_v   = gen && cmpl && !bad;
        pend_b0  = b0;
        pend_pec = b0p;
        pend_par = b0r;
        pend_clr = clr;
        if (!ok) pend_tag = "R2";
        else if (nack) pend_tag = "R3";
        else if (!hit) pend_tag = "R5";
        else if (ctrl[4]) pend_tag = "R12";
        else if (!cmpl) pend_tag = "R11";
        else if (bad) pend_tag = "R10";
        else if (pec) pend_tag = "R9";
        else pend_tag = "R6";
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 reset pec_en", cfg_pec_en_o, 0);
        chk("R1 reset irq_clr", irq_clr_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pec_en", cfg_pec_en_o, 0);
        chk("R1 par_dis", cfg_par_dis_o, 0);
        chk("R1 irq_clr", irq_clr_o, 0);
        chk("R1 ack_valid", ack_valid_o, 0);
        chk("R1 reg_access", reg_access_o, 0);

        // Directed: broadcast, both control bits and the clear pulse (R7, R8)
        dat[0] = 8'hFF; dat[1] = 8'hF7 | 8'h08;
        run_frame(0, 0, 8'hFC, CMD, 8'hE0, 8'h00, 2, 0, 0, 0);
        do_stop();
        // Directed: PEC on, two data bytes, good check byte (R9)
        dat[0] = 8'h3F; dat[1] = 8'h00;
        run_frame(0, 1, 8'hFC, CMD, 8'hE1, 8'h12, 2, 1, 1, 0);
        do_stop();
        // Directed: bad PEC (R10), then repeated start is NACKed (R3)
        dat[0] = 8'hC0; dat[1] = 8'h08;
        run_frame(0, 1, 8'hFC, CMD, 8'hE1, 8'h00, 2, 2, 0, 0);
        run_frame(1, 0, 8'hFC, CMD, 8'hE0, 8'h00, 1, 0, 0, 0);
        do_stop();
        // Directed: unicast miss and reserved mask value (R5)
        dat[0] = 8'hC0;
        run_frame(0, 0, 8'hFC, CMD, 8'h00, {7'h34, 1'b0}, 1, 0, 0, 0);
        run_frame(0, 0, 8'hFC, CMD, 8'h40, {OWN, 1'b1}, 1, 0, 0, 0);
        // Directed: group match, offset 3 pushes data past byte 3 (R6)
        dat[0] = 8'h08; dat[1] = 8'hC0; dat[2] = 8'hC0;
        run_frame(0, 0, 8'hFC, CMD, 8'h6C, {4'b0110, 3'b001, 1'b0}, 3, 0, 0, 0);
        // Directed: offset 1 places first byte at clear position (R6, R8)
        dat[0] = 8'h08;
        run_frame(0, 0, 8'hFC, CMD, 8'hE4, 8'h00, 1, 0, 0, 0);
        // Directed: register-access flag (R12) and empty frame (R11)
        run_frame(0, 0, 8'hFC, CMD, 8'hF0, 8'h00, 1, 0, 0, 0);
        run_frame(0, 0, 8'hFC, CMD, 8'hE0, 8'h00, 0, 0, 0, 0);
        // Directed: parity error, then repeated start NACK (R13)
        dat[0] = 8'hC0;
        run_frame(0, 0, 8'hFC, CMD, 8'hE0, 8'h00, 1, 0, 0, 1);
        run_frame(1, 0, 8'hFC, CMD, 8'hE0, 8'h00, 1, 0, 0, 0);
        do_stop();

        for (int f = 0; f < 500; f++) begin
            bit rs, pec, par;
            logic [7:0] hdr, code, ctrl, addr;
            int nd, pk, tail, sel;
            rs   = open_fr && ($urandom % 3 == 0);
            pec  = $urandom % 2;
            par  = ($urandom % 12 == 0);
            hdr  = ($urandom % 16 == 0) ? 8'($urandom) : 8'hFC;
            code = ($urandom % 16 == 0) ? 8'($urandom) : CMD;
            ctrl = 8'($urandom);
            sel  = $urandom % 8;
            if (sel < 3) ctrl[7:5] = 3'b111;
            else if (sel < 5) ctrl[7:5] = 3'b011;
            else if (sel < 7) ctrl[7:5] = 3'b000;
            ctrl[4] = ($urandom % 8 == 0);
            sel  = $urandom % 3;
            if (sel == 0) addr = {OWN, 1'($urandom)};
            else if (sel == 1) addr = {OWN[6:3], 3'($urandom), 1'($urandom)};
            else addr = 8'($urandom);
            for (int i = 0; i < 5; i++) dat[i] = 8'($urandom);
            tail = 0;
            if (pec) begin
                if ($urandom % 6 == 0) begin
                    nd = $urandom % (int'(ctrl[1:0]) + 1);
                    pk = 0;
                end else begin
                    nd = int'(ctrl[1:0]) + 1;
                    pk = ($urandom % 5 == 0) ? 2 : 1;
                    tail = (pk == 1) ? int'($urandom % 2) : 0;
                end
            end else begin
                nd = $urandom % 6;
                pk = 0;
            end
            run_frame(rs, pec, hdr, code, ctrl, addr, nd, pk, tail, par);
        end
        if (open_fr) do_stop();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule